// File: doc/BRIEF.md
# Sequential Restoring Square Root Unit

This block extracts the integer square root of an unsigned radicand of 2n bits, with n = 4 by default. It is multi-cycle and has a single shared subtractor. A one-cycle start request captures the radicand. The unit then settles one root bit per clock, beginning with the most significant. When it finishes, it reports the root Q and a remainder R such that A = Q*Q + R.

Each iteration forms a trial term from the partial root with the two bits 0 and 1 appended, and aligns it left by twice the remaining step index. The subtractor takes this term away from the full-width remainder. The sign of the difference decides two things: the new root bit, and whether the remainder takes the difference or keeps its old value. This is restoring by not loading.

A busy flag covers the iterations, and a single-cycle done flag marks the results as valid. The results stay put until the next accepted start. A start request that arrives while the unit is busy has no effect.

Top module: `sqrt_restoring_unit`

## Requirements
- R1: After reset, busy, done, root and remainder are all zero. A start sampled high while busy is low loads the radicand into the remainder register and clears the root, so on the next cycle root reads 0 and remainder reads the low n+1 bits of the radicand.
- R2: Once a start is accepted, busy is high for exactly n cycles. The accepted start is at clock edge 0, and busy falls at edge n.
- R3: Done is high for exactly one cycle, the cycle after edge n, which is the first cycle with busy low. Done never stays high for two cycles in a row.
- R4: Each iteration shifts the root left by one place and inserts the new bit at bit 0, so the root bits arrive most significant first.
- R5: In step k (k = n-1 down to 0), the trial term is (4*P + 1) * 4^k, where P is the current root register. If the remainder is at least the trial term, the new root bit is 1 and the remainder becomes the difference.
- R6: If the remainder is below the trial term, the new root bit is 0 and the remainder is left unchanged.
- R7: When done is high, root = floor(sqrt(A)), remainder = A - root*root, and remainder <= 2*root.
- R8: A start asserted while busy is high is ignored. The operation in progress completes with the result for the radicand captured at its own start, and it takes the same n cycles.
- R9: While busy is low and start is low, root and remainder keep their values, whatever the radicand input does.
- R10: The corner results are: A = 0 gives Q = 0, R = 0; A = 11 gives Q = 3, R = 2; A = 2^(2n)-1 gives Q = 2^n-1, R = 2^(n+1)-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an extraction; taken only while busy is low |
| radicand | input | 2*ROOT_W | Unsigned input A, sampled on an accepted start |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when root and remainder are final |
| root | output | ROOT_W | Integer square root Q |
| remainder | output | ROOT_W+1 | Remainder R = A - Q*Q |

## Verification
The bench builds the unit at its default width of n = 4, with an 8-bit radicand. At that size every one of the 256 radicands can be run end to end in a few thousand cycles, so both extremes, the zero input and every perfect square are covered without sampling. A behavioural model tracks the root and remainder through every intermediate step and is compared with the outputs on every clock. This exposes a wrong root bit or a wrong restore decision in the very step where it first happens. Dedicated runs add start pulses during busy and radicand changes while idle.

// File: rtl/sqrt_restoring_pkg.sv
package sqrt_restoring_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture radicand, clear root
    logic step;   // perform one trial subtraction and update
  } sqrtStrobes_t;

endpackage

// File: rtl/sqrt_restoring_ctrl.sv
module sqrt_restoring_ctrl
  import sqrt_restoring_pkg::*;
#(
  parameter int ROOT_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output sqrtStrobes_t     strobes,
  output logic [CNT_W-1:0] shiftIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROOT_W - 1);

  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (stepCnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stepCnt <= stepCnt - CNT_W'(1);
        end
      end else if (start) begin
        busy    <= 1'b1;
        stepCnt <= LAST_IDX;
      end
    end
  end

  always_comb begin
    strobes.load = start && !busy;
    strobes.step = busy;
    shiftIdx     = stepCnt;
  end

  // R2: an accepted start opens a run at the top step index
  a_r2_launch: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && stepCnt == LAST_IDX));

  // R2: the index falls by one each busy cycle until zero
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepCnt != '0) |=> (busy && stepCnt == $past(stepCnt) - CNT_W'(1)));

  // R2 and R3: the final step ends the run and raises done
  a_r2_finish: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepCnt == '0) |=> (!busy && done));

  // R3: done lasts a single cycle
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: a start during a non-final busy cycle does not restart the count
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && stepCnt != '0) |=> (stepCnt != LAST_IDX || ROOT_W == 1));

endmodule

// File: rtl/sqrt_restoring_datapath.sv
module sqrt_restoring_datapath
  import sqrt_restoring_pkg::*;
#(
  parameter int ROOT_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sqrtStrobes_t          strobes,
  input  logic [CNT_W-1:0]      shiftIdx,
  input  logic [2*ROOT_W-1:0]   radicand,
  output logic [ROOT_W-1:0]     root,
  output logic [ROOT_W:0]       remainder
);

  localparam int RAD_W = 2 * ROOT_W;
  localparam int EXT_W = RAD_W + 1;   // one extra bit carries the sign

  logic [RAD_W-1:0]  remReg;
  logic [ROOT_W-1:0] rootReg;
  logic [EXT_W-1:0]  trialTerm;
  logic [EXT_W-1:0]  trialDiff;
  logic              trialNeg;
  logic [RAD_W-1:0]  remNext;

  // Trial term {root,0,1} aligned left by twice the step index.
  always_comb begin
    trialTerm = EXT_W'({rootReg, 2'b01}) << {shiftIdx, 1'b0};
    trialDiff = {1'b0, remReg} - trialTerm;
    trialNeg  = trialDiff[EXT_W-1];
    remNext   = trialNeg ? remReg : trialDiff[RAD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      rootReg <= '0;
    end else if (strobes.load) begin
      remReg  <= radicand;
      rootReg <= '0;
    end else if (strobes.step) begin
      remReg  <= remNext;
      rootReg <= {rootReg[ROOT_W-2:0], ~trialNeg};
    end
  end

  assign root      = rootReg;
  assign remainder = remReg[ROOT_W:0];

  // R1: load captures the radicand and clears the root
  a_r1_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (rootReg == '0 && remReg == $past(radicand)));

  // R4: each step shifts the root left by one place
  a_r4_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (rootReg[ROOT_W-1:1] == $past(rootReg[ROOT_W-2:0])));

  // R5: an accepted trial strictly reduces the remainder
  a_r5_accept: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !trialNeg) |=> (remReg < $past(remReg) && rootReg[0]));

  // R6: a rejected trial keeps the remainder
  a_r6_restore: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && trialNeg) |=> ($stable(remReg) && !rootReg[0]));

endmodule

// File: rtl/sqrt_restoring_unit.sv
module sqrt_restoring_unit
  import sqrt_restoring_pkg::*;
#(
  parameter int ROOT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2*ROOT_W-1:0] radicand,
  output logic                busy,
  output logic                done,
  output logic [ROOT_W-1:0]   root,
  output logic [ROOT_W:0]     remainder
);

  localparam int CNT_W = (ROOT_W > 1) ? $clog2(ROOT_W) : 1;

  sqrtStrobes_t     strobes;
  logic [CNT_W-1:0] shiftIdx;

  sqrt_restoring_ctrl #(.ROOT_W(ROOT_W), .CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .strobes  (strobes),
    .shiftIdx (shiftIdx),
    .busy     (busy),
    .done     (done)
  );

  sqrt_restoring_datapath #(.ROOT_W(ROOT_W), .CNT_W(CNT_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .shiftIdx  (shiftIdx),
    .radicand  (radicand),
    .root      (root),
    .remainder (remainder)
  );

  // R7: the final remainder never exceeds twice the root
  a_r7_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ({1'b0, remainder} <= {1'b0, root, 1'b0}));

  // R9: idle results stay constant without a start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(root) && $stable(remainder)));

endmodule

// File: tb/sqrt_restoring_unit_tb_top.sv
module sqrt_restoring_unit_tb_top;

  localparam int N     = 4;
  localparam int RAD_W = 2 * N;
  localparam int MAXA  = (1 << RAD_W) - 1;
  localparam int RMASK = (1 << (N + 1)) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [RAD_W-1:0] radicand = '0;
  logic             busy;
  logic             done;
  logic [N-1:0]     root;
  logic [N:0]       remainder;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  sqrt_restoring_unit #(.ROOT_W(N)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .radicand(radicand),
    .busy(busy), .done(done), .root(root), .remainder(remainder)
  );

  task automatic chk(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycleCount);
    end
  endtask

  // Behavioural reference: state advanced at each rising edge.
  int  mRem = 0, mRoot = 0, mCnt = 0;
  bit  mBusy = 0, mDone = 0;

  always @(posedge clk) begin
    cycleCount++;
    if (!rstN) begin
      mRem = 0; mRoot = 0; mCnt = 0; mBusy = 0; mDone = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        int trial;
        trial = (4 * mRoot + 1) * (1 << (2 * mCnt));
        if (mRem >= trial) begin
          mRem  = mRem - trial;
          mRoot = 2 * mRoot + 1;
        end else begin
          mRoot = 2 * mRoot;
        end
        if (mCnt == 0) begin
          mBusy = 0;
          mDone = 1;
        end else begin
          mCnt = mCnt - 1;
        end
      end else if (start) begin
        mRem  = int'(radicand);
        mRoot = 0;
        mBusy = 1;
        mCnt  = N - 1;
      end
    end
  end

  // Per-cycle comparison covering R4, R5 and R6 step by step.
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 busy per-cycle", int'(busy), int'(mBusy));
      chk("R3 done per-cycle", int'(done), int'(mDone));
      chk("R4 root per-cycle", int'(root), mRoot);
      chk("R5/R6 remainder per-cycle", int'(remainder), mRem & RMASK);
    end
  end

  function automatic int isqrt(input int a);
    int q = 0;
    while ((q + 1) * (q + 1) <= a) q++;
    return q;
  endfunction

  // Runs one extraction; optionally pokes start during busy.
  task automatic runOp(input int a, input bit pokeBusy, input string tag);
    int cyc;
    int q;
    @(negedge clk);
    start = 1'b1;
    radicand = RAD_W'(a);
    @(negedge clk);
    cyc = 0;
    start = 1'b0;
    chk("R1 root cleared after load", int'(root), 0);
    chk("R1 remainder loaded", int'(remainder), a & RMASK);
    while (!done && cyc < 50) begin
      if (pokeBusy) begin
        start = 1'b1;
        radicand = RAD_W'(a ^ 8'h5A);
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    q = isqrt(a);
    chk({tag, " cycles to done (R2)"}, cyc, N);
    chk({tag, " busy low with done (R3)"}, int'(busy), 0);
    chk({tag, " root (R7)"}, int'(root), q);
    chk({tag, " remainder (R7)"}, int'(remainder), a - q * q);
  endtask

  initial begin
    int sRoot, sRem;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset root", int'(root), 0);
    chk("R1 reset remainder", int'(remainder), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R10 corners
    runOp(11, 1'b0, "R10 A=11");
    chk("R10 A=11 root", int'(root), 3);
    chk("R10 A=11 remainder", int'(remainder), 2);
    runOp(0, 1'b0, "R10 A=0");
    chk("R10 A=0 root", int'(root), 0);
    chk("R10 A=0 remainder", int'(remainder), 0);
    runOp(MAXA, 1'b0, "R10 A=max");
    chk("R10 A=max root", int'(root), (1 << N) - 1);
    chk("R10 A=max remainder", int'(remainder), (1 << (N + 1)) - 2);

    // R7 exhaustive sweep
    for (int a = 0; a <= MAXA; a++) runOp(a, 1'b0, "R7 sweep");

    // R8: start held during busy is ignored
    runOp(200, 1'b1, "R8 start during busy");
    chk("R8 done single pulse (R3)", int'(done), 1);
    @(negedge clk);
    chk("R3 done cleared next cycle", int'(done), 0);

    // R9: hold while idle with changing radicand
    runOp(150, 1'b0, "R9 setup");
    sRoot = int'(root);
    sRem  = int'(remainder);
    for (int i = 0; i < 6; i++) begin
      radicand = RAD_W'(i * 37 + 3);
      @(negedge clk);
    end
    chk("R9 root held", int'(root), sRoot);
    chk("R9 remainder held", int'(remainder), sRem);
    chk("R9 busy stays low", int'(busy), 0);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    wait (cycleCount > 100000);
    failCount++;
    $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycleCount);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule